// File: doc/BRIEF.md
# Nine-Bit Multidrop Address Filter

This block sits on the receive path of a serial port that is set for nine-bit characters. It sits between the shifter that assembles each character and the receive FIFO. In a multidrop link, a ninth bit of 1 marks a character as an address and a ninth bit of 0 marks it as data. The receive side checks parity against a forced expected value of 0. Because of this, every address character shows up to software with its error flag set. The filter decides, one character at a time, whether the character reaches the FIFO, which flag goes with it, and whether it raises a line-status interrupt request.

There are two address modes. In manual mode, software owns the receiver state through a pair of enable and disable pulses. Every address is handed to software, flagged, whatever the current state. In automatic mode, the filter compares each address with a programmed station address. On a match it switches reception on. On a mismatch it switches reception off. With nine-bit mode turned off, the filter becomes a plain pass-through.

The receiver state machine has two states: `RX_OFF` (reception disabled) and `RX_ON` (reception enabled). It has four named transitions:

- `T_SW_ON`: a software enable pulse moves any state to `RX_ON`.
- `T_SW_OFF`: a software disable pulse moves any state to `RX_OFF`.
- `T_AUTO_HIT`: in automatic mode, a matching address moves `RX_OFF` to `RX_ON`.
- `T_AUTO_MISS`: in automatic mode, a non-matching address moves `RX_ON` to `RX_OFF`.

Top module: `mdrop_addr_filter`

## Requirements
- R1: After reset the receiver is in `RX_OFF`, and both `push_valid` and `lsi_req` are 0. With `nine_bit_en`=1, `rx_enabled` reads 0.
- R2: With `nine_bit_en`=0, every character is pushed with `push_flag`=0 and no `lsi_req`, whatever its ninth bit. In this mode `rx_enabled` reads 1.
- R3: In manual mode (`nine_bit_en`=1, `auto_addr_en`=0), data characters (ninth bit 0) arriving in `RX_OFF` are not pushed.
- R4: In manual mode, every address character (ninth bit 1) is pushed with `push_flag`=1 in either state. Address characters leave the state unchanged.
- R5: In manual mode, only `sw_rx_on` and `sw_rx_off` change the state. In `RX_ON`, data characters are pushed with `push_flag`=0 and no `lsi_req`.
- R6: In automatic mode (`nine_bit_en`=1, `auto_addr_en`=1) in `RX_OFF`, data characters and addresses different from `station_addr` are not pushed.
- R7: In automatic mode, an address equal to `station_addr` that arrives in `RX_OFF` is pushed with `push_flag`=1 (the ninth bit) and takes transition `T_AUTO_HIT`.
- R8: In automatic mode, an address different from `station_addr` that arrives in `RX_ON` is not pushed and takes transition `T_AUTO_MISS`.
- R9: In automatic mode, a matching address that arrives in `RX_ON` is pushed again with `push_flag`=1, and the state stays `RX_ON`.
- R10: A software pulse in the same cycle as an automatic transition decides the next state. If `sw_rx_on` and `sw_rx_off` are both high, `sw_rx_off` wins.
- R11: A character strobed at a clock edge appears on the push outputs just after that edge, for exactly one cycle. Back-to-back strobes give back-to-back pushes. Each character is judged by the state in force before its own edge.
- R12: `lsi_req` pulses together with a flagged push only when `lsi_enable` was 1 at the strobe. It never pulses without a flagged push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chr_valid | input | 1 | One-cycle strobe: a received character is present |
| chr_data | input | DATA_W | Low eight bits of the received character |
| chr_bit9 | input | 1 | Ninth bit; 1 marks an address |
| nine_bit_en | input | 1 | Enables multidrop filtering |
| auto_addr_en | input | 1 | Selects automatic (1) or manual (0) address mode |
| station_addr | input | DATA_W | Programmed station address |
| sw_rx_on | input | 1 | Software pulse that enables reception |
| sw_rx_off | input | 1 | Software pulse that disables reception |
| lsi_enable | input | 1 | Line-status interrupt enable |
| push_valid | output | 1 | FIFO push strobe |
| push_data | output | DATA_W | Byte to store |
| push_flag | output | 1 | Status flag stored with the byte (error / ninth bit) |
| lsi_req | output | 1 | Line-status interrupt request pulse |
| rx_enabled | output | 1 | Current receiver-enabled state |

## Verification
`push_valid`, `push_data`, `push_flag` and `lsi_req` are due one rising edge after the strobe edge. `rx_enabled` reflects the new state one edge after the strobe or software pulse that changed it. It also follows `nine_bit_en` with no delay, because pass-through mode forces it high. The bench drives inputs shortly after each rising edge. Its reference model updates at the rising edge. Every output is compared at the falling edge that follows, so each result is read half a cycle after it is due and before the next input change. The combined cases, where software pulses coincide with automatic transitions and strobes arrive back to back, are driven deliberately so that the priority and the state-before-edge rule are each observed at the outputs.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;

    typedef enum logic [0:0] {
        RX_OFF = 1'b0,
        RX_ON  = 1'b1
    } rx_state_e;

    typedef enum logic [1:0] {
        CH_DATA      = 2'd0,
        CH_ADDR_HIT  = 2'd1,
        CH_ADDR_MISS = 2'd2
    } char_kind_e;

    typedef struct packed {
        logic valid;
        logic flag;
        logic irq;
    } push_dec_t;

endpackage

// File: rtl/mdrop_classify.sv
module mdrop_classify
    import mdrop_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              chr_bit9,
    input  logic [DATA_W-1:0] chr_data,
    input  logic [DATA_W-1:0] station_addr,
    output char_kind_e        kind
);

    always_comb begin
        if (!chr_bit9) begin
            kind = CH_DATA;
        end else if (chr_data == station_addr) begin
            kind = CH_ADDR_HIT;
        end else begin
            kind = CH_ADDR_MISS;
        end
    end

endmodule

// File: rtl/mdrop_rx_fsm.sv
module mdrop_rx_fsm
    import mdrop_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chr_valid,
    input  logic       nine_bit_en,
    input  logic       auto_addr_en,
    input  char_kind_e kind,
    input  logic       sw_rx_on,
    input  logic       sw_rx_off,
    output logic       rx_on
);

    rx_state_e state_q;
    rx_state_e state_d;
    logic      auto_evt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: automatic ones first, software pulses override them
    always_comb begin
        auto_evt = chr_valid && nine_bit_en && auto_addr_en && (kind != CH_DATA);
        state_d  = state_q;
        unique case (state_q)
            RX_OFF: if (auto_evt && kind == CH_ADDR_HIT)  state_d = RX_ON;   // T_AUTO_HIT
            RX_ON:  if (auto_evt && kind == CH_ADDR_MISS) state_d = RX_OFF;  // T_AUTO_MISS
        endcase
        if (sw_rx_off) begin
            state_d = RX_OFF;                                                 // T_SW_OFF
        end else if (sw_rx_on) begin
            state_d = RX_ON;                                                  // T_SW_ON
        end
    end

    // Outputs
    always_comb begin
        rx_on = (state_q == RX_ON);
    end

endmodule

// File: rtl/mdrop_push_ctrl.sv
module mdrop_push_ctrl
    import mdrop_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chr_valid,
    input  logic [DATA_W-1:0] chr_data,
    input  char_kind_e        kind,
    input  logic              nine_bit_en,
    input  logic              auto_addr_en,
    input  logic              lsi_enable,
    input  logic              rx_on,
    output logic              push_valid,
    output logic [DATA_W-1:0] push_data,
    output logic              push_flag,
    output logic              lsi_req
);

    push_dec_t dec;

    always_comb begin
        dec = '0;
        if (chr_valid) begin
            if (!nine_bit_en) begin
                dec.valid = 1'b1;
            end else begin
                unique case (kind)
                    CH_DATA: begin
                        dec.valid = rx_on;
                    end
                    CH_ADDR_HIT: begin
                        dec.valid = 1'b1;
                        dec.flag  = 1'b1;
                        dec.irq   = lsi_enable;
                    end
                    CH_ADDR_MISS: begin
                        dec.valid = !auto_addr_en;
                        dec.flag  = !auto_addr_en;
                        dec.irq   = !auto_addr_en && lsi_enable;
                    end
                    default: dec = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            push_valid <= 1'b0;
            push_flag  <= 1'b0;
            lsi_req    <= 1'b0;
            push_data  <= '0;
        end else begin
            push_valid <= dec.valid;
            push_flag  <= dec.flag;
            lsi_req    <= dec.irq;
            if (chr_valid) begin
                push_data <= chr_data;
            end
        end
    end

endmodule

// File: rtl/mdrop_addr_filter.sv
module mdrop_addr_filter
    import mdrop_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chr_valid,
    input  logic [DATA_W-1:0] chr_data,
    input  logic              chr_bit9,
    input  logic              nine_bit_en,
    input  logic              auto_addr_en,
    input  logic [DATA_W-1:0] station_addr,
    input  logic              sw_rx_on,
    input  logic              sw_rx_off,
    input  logic              lsi_enable,
    output logic              push_valid,
    output logic [DATA_W-1:0] push_data,
    output logic              push_flag,
    output logic              lsi_req,
    output logic              rx_enabled
);

    char_kind_e kind;
    logic       rx_on;

    mdrop_classify #(.DATA_W(DATA_W)) i_classify (
        .chr_bit9     (chr_bit9),
        .chr_data     (chr_data),
        .station_addr (station_addr),
        .kind         (kind)
    );

    mdrop_rx_fsm i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .chr_valid    (chr_valid),
        .nine_bit_en  (nine_bit_en),
        .auto_addr_en (auto_addr_en),
        .kind         (kind),
        .sw_rx_on     (sw_rx_on),
        .sw_rx_off    (sw_rx_off),
        .rx_on        (rx_on)
    );

    mdrop_push_ctrl #(.DATA_W(DATA_W)) i_push (
        .clk          (clk),
        .rst_n        (rst_n),
        .chr_valid    (chr_valid),
        .chr_data     (chr_data),
        .kind         (kind),
        .nine_bit_en  (nine_bit_en),
        .auto_addr_en (auto_addr_en),
        .lsi_enable   (lsi_enable),
        .rx_on        (rx_on),
        .push_valid   (push_valid),
        .push_data    (push_data),
        .push_flag    (push_flag),
        .lsi_req      (lsi_req)
    );

    assign rx_enabled = rx_on || !nine_bit_en;

endmodule

// File: rtl/mdrop_filter_checker.sv
module mdrop_filter_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chr_valid,
    input logic [DATA_W-1:0] chr_data,
    input logic              chr_bit9,
    input logic              nine_bit_en,
    input logic              auto_addr_en,
    input logic [DATA_W-1:0] station_addr,
    input logic              sw_rx_on,
    input logic              sw_rx_off,
    input logic              lsi_enable,
    input logic              push_valid,
    input logic [DATA_W-1:0] push_data,
    input logic              push_flag,
    input logic              lsi_req,
    input logic              rx_enabled
);

    assert_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
        chr_valid && !nine_bit_en |=> push_valid && !push_flag && !lsi_req && push_data == $past(chr_data));

    assert_drop_data_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        chr_valid && nine_bit_en && !chr_bit9 && !rx_enabled |=> !push_valid);

    assert_manual_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        chr_valid && nine_bit_en && !auto_addr_en && chr_bit9 |=> push_valid && push_flag);

    assert_sw_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rx_on && !sw_rx_off |=> rx_enabled);

    assert_auto_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        chr_valid && nine_bit_en && auto_addr_en && chr_bit9 && chr_data != station_addr |=> !push_valid);

    assert_auto_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chr_valid && nine_bit_en && auto_addr_en && chr_bit9 && chr_data == station_addr && !sw_rx_off
        |=> push_valid && push_flag && rx_enabled);

    assert_sw_off_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rx_off |=> rx_enabled == !nine_bit_en);

    assert_push_needs_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |-> $past(chr_valid));

    assert_irq_with_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
        lsi_req |-> push_valid && push_flag && $past(lsi_enable));

endmodule

bind mdrop_addr_filter mdrop_filter_checker #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_mdrop_addr_filter.sv
module test_mdrop_addr_filter;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chr_valid = 1'b0;
    logic [DW-1:0] chr_data = '0;
    logic          chr_bit9 = 1'b0;
    logic          nine_bit_en = 1'b1;
    logic          auto_addr_en = 1'b0;
    logic [DW-1:0] station_addr = 8'h3C;
    logic          sw_rx_on = 1'b0;
    logic          sw_rx_off = 1'b0;
    logic          lsi_enable = 1'b1;
    logic          push_valid;
    logic [DW-1:0] push_data;
    logic          push_flag;
    logic          lsi_req;
    logic          rx_enabled;

    int    n_checks = 0;
    int    n_errors = 0;
    int    cycles   = 0;
    string cur_req  = "R1";
    bit    started  = 1'b0;
    bit    done     = 1'b0;

    // reference model state
    bit          m_en = 1'b0;
    bit          e_valid = 1'b0;
    bit          e_flag = 1'b0;
    bit          e_irq = 1'b0;
    logic [7:0]  e_data = '0;
    string       e_tag = "R1";

    always #4 clk = ~clk;

    mdrop_addr_filter #(.DATA_W(DW)) i_mdrop_addr_filter (
        .clk(clk), .rst_n(rst_n), .chr_valid(chr_valid), .chr_data(chr_data),
        .chr_bit9(chr_bit9), .nine_bit_en(nine_bit_en), .auto_addr_en(auto_addr_en),
        .station_addr(station_addr), .sw_rx_on(sw_rx_on), .sw_rx_off(sw_rx_off),
        .lsi_enable(lsi_enable), .push_valid(push_valid), .push_data(push_data),
        .push_flag(push_flag), .lsi_req(lsi_req), .rx_enabled(rx_enabled)
    );

    // behavioural reference, updated at each rising edge
    always @(posedge clk) begin
        started <= 1'b1;
        e_tag = cur_req;
        if (!rst_n) begin
            m_en = 1'b0; e_valid = 1'b0; e_flag = 1'b0; e_irq = 1'b0;
        end else begin
            e_valid = 1'b0; e_flag = 1'b0; e_irq = 1'b0;
            if (chr_valid) begin
                e_data = chr_data;
                if (!nine_bit_en) begin
                    e_valid = 1'b1;
                end else if (!chr_bit9) begin
                    e_valid = m_en;
                end else if (!auto_addr_en || chr_data == station_addr) begin
                    e_valid = 1'b1; e_flag = 1'b1; e_irq = lsi_enable;
                end
                if (nine_bit_en && auto_addr_en && chr_bit9)
                    m_en = (chr_data == station_addr);
            end
            if (sw_rx_on)  m_en = 1'b1;
            if (sw_rx_off) m_en = 1'b0;
        end
    end

    task automatic check(string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", e_tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            check("rx_enabled", rx_enabled, int'(m_en || !nine_bit_en));
            check("push_valid", push_valid, e_valid);
            check("lsi_req", lsi_req, e_irq);
            if (e_valid) begin
                check("push_flag", push_flag, e_flag);
                check("push_data", push_data, e_data);
            end
        end
    end

    task automatic cyc(bit v, logic [7:0] d, bit b9, bit on = 0, bit off = 0);
        @(posedge clk); #2;
        chr_valid = v; chr_data = d; chr_bit9 = b9; sw_rx_on = on; sw_rx_off = off;
    endtask

    task automatic idle(int n = 1);
        for (int i = 0; i < n; i++) cyc(0, 8'h00, 0);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        while (cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        finish_run();
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        idle(2);

        // R2: pass-through
        cur_req = "R2";
        nine_bit_en = 1'b0;
        cyc(1, 8'h11, 0);
        cyc(1, 8'h22, 1);
        idle(2);

        // R3: manual mode, data dropped while off
        cur_req = "R3";
        nine_bit_en = 1'b1;
        auto_addr_en = 1'b0;
        cyc(1, 8'h45, 0);
        idle(2);

        // R4: manual, every address flagged, state unchanged
        cur_req = "R4";
        cyc(1, 8'h05, 1);
        idle(1);
        cyc(1, 8'h3C, 1);
        idle(2);

        // R5: software enable, data pushed, software disable
        cur_req = "R5";
        cyc(0, 8'h00, 0, 1, 0);
        cyc(1, 8'h66, 0);
        cyc(1, 8'h77, 1);
        idle(1);
        cyc(0, 8'h00, 0, 0, 1);
        cyc(1, 8'h88, 0);
        idle(2);

        // R12: interrupt gating
        cur_req = "R12";
        lsi_enable = 1'b0;
        cyc(1, 8'h09, 1);
        idle(1);
        lsi_enable = 1'b1;
        cyc(1, 8'h0A, 1);
        idle(2);

        // R6: automatic mode, off, discards
        cur_req = "R6";
        auto_addr_en = 1'b1;
        station_addr = 8'h3C;
        cyc(1, 8'h3C, 0);
        cyc(1, 8'h10, 1);
        idle(2);

        // R7: matching address enables
        cur_req = "R7";
        cyc(1, 8'h3C, 1);
        idle(1);

        // R9: data then repeated match while on
        cur_req = "R9";
        cyc(1, 8'hA1, 0);
        cyc(1, 8'h3C, 1);
        idle(2);

        // R8: mismatch while on disables, then data dropped
        cur_req = "R8";
        cyc(1, 8'h10, 1);
        cyc(1, 8'hA2, 0);
        idle(2);

        // R10: software pulses against automatic transitions
        cur_req = "R10";
        cyc(1, 8'h3C, 1, 0, 1);
        cyc(1, 8'hB1, 0);
        cyc(0, 8'h00, 0, 1, 0);
        cyc(1, 8'h55, 1, 1, 0);
        cyc(1, 8'hB2, 0);
        cyc(0, 8'h00, 0, 1, 1);
        cyc(1, 8'hB3, 0);
        idle(2);

        // R11: back-to-back strobes, each judged by the state before its edge
        cur_req = "R11";
        cyc(1, 8'hC0, 0);
        cyc(1, 8'h3C, 1);
        cyc(1, 8'hC1, 0);
        cyc(1, 8'h11, 1);
        cyc(1, 8'hC2, 0);
        idle(1);
        auto_addr_en = 1'b0;
        cyc(1, 8'hD0, 1, 1, 0);
        cyc(1, 8'hD1, 0);
        cyc(1, 8'hD2, 0);
        idle(1);
        nine_bit_en = 1'b0;
        cyc(1, 8'hE0, 1);
        cyc(1, 8'hE1, 0);
        idle(3);

        finish_run();
    end

endmodule